// File: doc/BRIEF.md
# Segmented Time-Tagged Result Broadcast Bus

This block moves results from producer slots to consumer slots across a window of `NCOL` columns, each holding `NROW` slots. Every slot has a fixed time tag taken from its position, `tag = col*NROW + row`, so a lower tag means an earlier slot. A result carries an operand address, a kind (register, memory or predicate), a data value and the time tag of the slot that produced it. A producer in column `c` drives its result onto the bus segment of that column. A register stage copies each segment into the segment of the next column on the following clock edge. The wire length of one segment therefore stays the same however many columns are built. Results travel only toward later columns and are dropped after the last column.

Each column has an arbiter with two named states. In `ARB_PASS` the segment carries either the upstream result or the local injection. If both arrive in one cycle, the later-tagged result goes on the segment and the other is parked, and the arbiter moves `ARB_PASS -> ARB_HOLD`. In `ARB_HOLD` the parked result competes with upstream traffic and local injection is refused. The arbiter stays `ARB_HOLD -> ARB_HOLD` while upstream keeps colliding and returns `ARB_HOLD -> ARB_PASS` once the parked result has been driven.

Each consumer slot has two named states, `SLOT_EMPTY` and `SLOT_FULL`. A configuration write sets the address and kind the slot watches and sends it back to `SLOT_EMPTY`. The slot moves `SLOT_EMPTY -> SLOT_FULL` on its first qualifying capture. In `SLOT_FULL -> SLOT_FULL` it takes a new capture only from a producer at least as late as the one it already holds. A read port returns any slot's contents. The tag of every segment is visible at the ports.

Top module: `bcast_window`

## Requirements
- R1: After reset every slot is empty, every `inj_ready` bit is 1 and no segment carries a result.
- R2: A slot captures a passing result only when both its address and its kind match the slot's configured pair. Kind codes are 0 for register, 1 for memory and 2 for predicate. A result that differs in either field leaves the slot unchanged.
- R3: A slot captures only results whose producer tag is strictly lower than its own tag `col*NROW+row`. A result from the same or a later position is never taken.
- R4: A full slot replaces its value only with a result whose tag is greater than or equal to the tag it holds. An older result that arrives after a newer one is ignored.
- R5: With no contention, a result injected in column `c` appears on segment `c` in the same cycle and on segment `c+k` exactly `k` cycles later, with its original tag. Column `c+k` slots capture it at the end of that cycle.
- R6: A result leaves the window after the last column. It never appears again on any segment, and segment 0 carries only column-0 producers.
- R7: When an upstream result and a local injection meet in one column in one cycle, the later tag is driven that cycle and the other one is driven in the next cycle. `inj_ready` for that column is 0 during that next cycle.
- R8: An injection offered while that column's `inj_ready` is 0 is discarded and reaches no slot.
- R9: A configuration write sets a slot's watched address and kind and empties the slot. It takes precedence over a capture in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inj_valid | input | NCOL | Per column: a producer offers a result |
| inj_row | input | NCOL*RW | Per column: row of the producing slot |
| inj_addr | input | NCOL*AW | Per column: operand address of the result |
| inj_kind | input | NCOL*2 | Per column: kind code (0 reg, 1 mem, 2 pred) |
| inj_value | input | NCOL*DW | Per column: result value |
| inj_ready | output | NCOL | Per column: local injection is accepted this cycle |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_col | input | CW | Column of the slot being configured |
| cfg_row | input | RW | Row of the slot being configured |
| cfg_addr | input | AW | Address the slot will watch |
| cfg_kind | input | 2 | Kind the slot will watch |
| rd_col | input | CW | Column of the slot being read |
| rd_row | input | RW | Row of the slot being read |
| rd_have | output | 1 | Read slot holds a captured value |
| rd_tag | output | TW | Producer tag of the held value |
| rd_value | output | DW | Held value |
| seg_valid | output | NCOL | Per segment: a result is on it this cycle |
| seg_tag | output | NCOL*TW | Per segment: producer tag of that result |

## Verification
The functions that can coincide are the forwarding of an upstream result into a column and a local injection in that same column. The bench provokes this by injecting in column 0 and, one cycle later, in column 1, so that both reach segment 1 together. It then reads segment tags cycle by cycle to confirm that the later tag goes first, the parked one follows one cycle behind, and injection is refused while the result is parked. Slot contents are then used to judge the effect of the reordering. Later slots must keep the newer value even though the older result reached them afterwards, and a refused injection must be absent everywhere.

// File: rtl/bbus_pkg.sv
package bbus_pkg;

    typedef enum logic [1:0] {
        KIND_REG  = 2'd0,
        KIND_MEM  = 2'd1,
        KIND_PRED = 2'd2
    } kind_e;

    typedef enum logic {
        ARB_PASS = 1'b0,
        ARB_HOLD = 1'b1
    } arb_state_e;

    typedef enum logic {
        SLOT_EMPTY = 1'b0,
        SLOT_FULL  = 1'b1
    } slot_state_e;

endpackage

// File: rtl/bbus_link.sv
// Register stage joining the end of one segment to the start of the next.
module bbus_link
    import bbus_pkg::*;
#(
    parameter int AW = 6,
    parameter int DW = 16,
    parameter int TW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [AW-1:0] in_addr,
    input  kind_e         in_kind,
    input  logic [TW-1:0] in_tag,
    input  logic [DW-1:0] in_value,
    output logic          out_valid,
    output logic [AW-1:0] out_addr,
    output kind_e         out_kind,
    output logic [TW-1:0] out_tag,
    output logic [DW-1:0] out_value
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_addr  <= '0;
            out_kind  <= KIND_REG;
            out_tag   <= '0;
            out_value <= '0;
        end else begin
            out_valid <= in_valid;
            out_addr  <= in_addr;
            out_kind  <= in_kind;
            out_tag   <= in_tag;
            out_value <= in_value;
        end
    end

    // R5: one cycle per column crossed, tag unchanged
    p_link_delay_r5: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_valid && out_tag == $past(in_tag) && out_value == $past(in_value)));

endmodule

// File: rtl/bbus_arbiter.sv
// Per-column merge of the upstream result and the local injection.
module bbus_arbiter
    import bbus_pkg::*;
#(
    parameter int AW = 6,
    parameter int DW = 16,
    parameter int TW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          up_valid,
    input  logic [AW-1:0] up_addr,
    input  kind_e         up_kind,
    input  logic [TW-1:0] up_tag,
    input  logic [DW-1:0] up_value,
    input  logic          loc_valid,
    input  logic [AW-1:0] loc_addr,
    input  kind_e         loc_kind,
    input  logic [TW-1:0] loc_tag,
    input  logic [DW-1:0] loc_value,
    output logic          loc_ready,
    output logic          out_valid,
    output logic [AW-1:0] out_addr,
    output kind_e         out_kind,
    output logic [TW-1:0] out_tag,
    output logic [DW-1:0] out_value
);

    arb_state_e state, state_nxt;

    logic          h_valid;
    logic [AW-1:0] h_addr;
    kind_e         h_kind;
    logic [TW-1:0] h_tag;
    logic [DW-1:0] h_value;

    logic          b_valid;
    logic [AW-1:0] b_addr;
    kind_e         b_kind;
    logic [TW-1:0] b_tag;
    logic [DW-1:0] b_value;

    logic          both;
    logic          up_wins;
    logic          pick_up;
    logic [AW-1:0] lose_addr;
    kind_e         lose_kind;
    logic [TW-1:0] lose_tag;
    logic [DW-1:0] lose_value;

    // second contender: local injection when passing, parked result when holding
    always_comb begin
        unique case (state)
            ARB_PASS: begin
                b_valid = loc_valid;
                b_addr  = loc_addr;
                b_kind  = loc_kind;
                b_tag   = loc_tag;
                b_value = loc_value;
            end
            ARB_HOLD: begin
                b_valid = h_valid;
                b_addr  = h_addr;
                b_kind  = h_kind;
                b_tag   = h_tag;
                b_value = h_value;
            end
        endcase
    end

    assign both    = up_valid && b_valid;
    assign up_wins = up_tag > b_tag;
    assign pick_up = both ? up_wins : up_valid;

    // output process
    always_comb begin
        loc_ready = (state == ARB_PASS);
        out_valid = up_valid || b_valid;
        if (pick_up) begin
            out_addr  = up_addr;
            out_kind  = up_kind;
            out_tag   = up_tag;
            out_value = up_value;
            lose_addr  = b_addr;
            lose_kind  = b_kind;
            lose_tag   = b_tag;
            lose_value = b_value;
        end else begin
            out_addr  = b_addr;
            out_kind  = b_kind;
            out_tag   = b_tag;
            out_value = b_value;
            lose_addr  = up_addr;
            lose_kind  = up_kind;
            lose_tag   = up_tag;
            lose_value = up_value;
        end
    end

    // next-state logic
    always_comb begin
        unique case (state)
            ARB_PASS: state_nxt = both ? ARB_HOLD : ARB_PASS;
            ARB_HOLD: state_nxt = both ? ARB_HOLD : ARB_PASS;
        endcase
    end

    // state register with parked result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ARB_PASS;
            h_valid <= 1'b0;
            h_addr  <= '0;
            h_kind  <= KIND_REG;
            h_tag   <= '0;
            h_value <= '0;
        end else begin
            state   <= state_nxt;
            h_valid <= both;
            if (both) begin
                h_addr  <= lose_addr;
                h_kind  <= lose_kind;
                h_tag   <= lose_tag;
                h_value <= lose_value;
            end
        end
    end

    // R7: on a collision the later tag is driven
    p_later_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && loc_valid && loc_ready) |-> (out_valid && out_tag >= up_tag && out_tag >= loc_tag));

    // R7: the parked result goes out in the next cycle, injection refused meanwhile
    p_park_drains_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && loc_valid && loc_ready) |=> (out_valid && !loc_ready));

    // R8: while refusing injection the segment is never idle
    p_hold_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !loc_ready |-> out_valid);

endmodule

// File: rtl/bbus_slot.sv
// Consumer slot: compares each passing result and captures matching ones.
module bbus_slot
    import bbus_pkg::*;
#(
    parameter int AW     = 6,
    parameter int DW     = 16,
    parameter int TW     = 3,
    parameter int MY_TAG = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_valid,
    input  logic [AW-1:0] bus_addr,
    input  kind_e         bus_kind,
    input  logic [TW-1:0] bus_tag,
    input  logic [DW-1:0] bus_value,
    input  logic          cfg_hit,
    input  logic [AW-1:0] cfg_addr,
    input  kind_e         cfg_kind,
    output logic          have,
    output logic [TW-1:0] val_tag,
    output logic [DW-1:0] value
);

    localparam logic [TW-1:0] OWN_TAG = TW'(MY_TAG);

    slot_state_e   state, state_nxt;
    logic [AW-1:0] w_addr;
    kind_e         w_kind;
    logic          hit;
    logic          take;

    assign hit = bus_valid && (bus_addr == w_addr) && (bus_kind == w_kind)
                 && (bus_tag < OWN_TAG);

    always_comb begin
        take = 1'b0;
        unique case (state)
            SLOT_EMPTY: take = hit;
            SLOT_FULL:  take = hit && (bus_tag >= val_tag);
        endcase
    end

    always_comb begin
        unique case (state)
            SLOT_EMPTY: state_nxt = take ? SLOT_FULL : SLOT_EMPTY;
            SLOT_FULL:  state_nxt = SLOT_FULL;
        endcase
        if (cfg_hit) state_nxt = SLOT_EMPTY;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= SLOT_EMPTY;
            w_addr  <= '0;
            w_kind  <= KIND_REG;
            val_tag <= '0;
            value   <= '0;
        end else begin
            state <= state_nxt;
            if (cfg_hit) begin
                w_addr <= cfg_addr;
                w_kind <= cfg_kind;
            end else if (take) begin
                val_tag <= bus_tag;
                value   <= bus_value;
            end
        end
    end

    assign have = (state == SLOT_FULL);

    // R3: a held value always comes from an earlier position
    p_tag_before_me_r3: assert property (@(posedge clk) disable iff (!rst_n)
        have |-> (val_tag < OWN_TAG));

    // R4: the held producer never moves backward in time
    p_no_regress_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (have && !cfg_hit) |=> (have && val_tag >= $past(val_tag)));

    // R9: configuration empties the slot
    p_cfg_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_hit |=> !have);

endmodule

// File: rtl/bcast_window.sv
module bcast_window
    import bbus_pkg::*;
#(
    parameter int NCOL = 4,
    parameter int NROW = 2,
    parameter int AW   = 6,
    parameter int DW   = 16,
    localparam int CW    = (NCOL > 1) ? $clog2(NCOL) : 1,
    localparam int RW    = (NROW > 1) ? $clog2(NROW) : 1,
    localparam int NSLOT = NCOL * NROW,
    localparam int TW    = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NCOL-1:0]      inj_valid,
    input  logic [NCOL*RW-1:0]   inj_row,
    input  logic [NCOL*AW-1:0]   inj_addr,
    input  logic [NCOL*2-1:0]    inj_kind,
    input  logic [NCOL*DW-1:0]   inj_value,
    output logic [NCOL-1:0]      inj_ready,
    input  logic                 cfg_we,
    input  logic [CW-1:0]        cfg_col,
    input  logic [RW-1:0]        cfg_row,
    input  logic [AW-1:0]        cfg_addr,
    input  logic [1:0]           cfg_kind,
    input  logic [CW-1:0]        rd_col,
    input  logic [RW-1:0]        rd_row,
    output logic                 rd_have,
    output logic [TW-1:0]        rd_tag,
    output logic [DW-1:0]        rd_value,
    output logic [NCOL-1:0]      seg_valid,
    output logic [NCOL*TW-1:0]   seg_tag
);

    // segment contents per column
    logic          seg_v [NCOL];
    logic [AW-1:0] seg_a [NCOL];
    kind_e         seg_k [NCOL];
    logic [TW-1:0] seg_t [NCOL];
    logic [DW-1:0] seg_d [NCOL];

    // arrivals from the previous column's register stage
    logic          up_v [NCOL];
    logic [AW-1:0] up_a [NCOL];
    kind_e         up_k [NCOL];
    logic [TW-1:0] up_t [NCOL];
    logic [DW-1:0] up_d [NCOL];

    logic          sl_have [NSLOT];
    logic [TW-1:0] sl_tag  [NSLOT];
    logic [DW-1:0] sl_val  [NSLOT];

    for (genvar c = 0; c < NCOL; c++) begin : g_col
        logic [TW-1:0] loc_tag;
        assign loc_tag = TW'(c * NROW) + TW'(inj_row[c*RW +: RW]);

        if (c == 0) begin : g_head
            assign up_v[c] = 1'b0;
            assign up_a[c] = '0;
            assign up_k[c] = KIND_REG;
            assign up_t[c] = '0;
            assign up_d[c] = '0;
        end else begin : g_link
            bbus_link #(.AW(AW), .DW(DW), .TW(TW)) u_link (
                .clk       (clk),
                .rst_n     (rst_n),
                .in_valid  (seg_v[c-1]),
                .in_addr   (seg_a[c-1]),
                .in_kind   (seg_k[c-1]),
                .in_tag    (seg_t[c-1]),
                .in_value  (seg_d[c-1]),
                .out_valid (up_v[c]),
                .out_addr  (up_a[c]),
                .out_kind  (up_k[c]),
                .out_tag   (up_t[c]),
                .out_value (up_d[c])
            );
        end

        bbus_arbiter #(.AW(AW), .DW(DW), .TW(TW)) u_arb (
            .clk       (clk),
            .rst_n     (rst_n),
            .up_valid  (up_v[c]),
            .up_addr   (up_a[c]),
            .up_kind   (up_k[c]),
            .up_tag    (up_t[c]),
            .up_value  (up_d[c]),
            .loc_valid (inj_valid[c]),
            .loc_addr  (inj_addr[c*AW +: AW]),
            .loc_kind  (kind_e'(inj_kind[c*2 +: 2])),
            .loc_tag   (loc_tag),
            .loc_value (inj_value[c*DW +: DW]),
            .loc_ready (inj_ready[c]),
            .out_valid (seg_v[c]),
            .out_addr  (seg_a[c]),
            .out_kind  (seg_k[c]),
            .out_tag   (seg_t[c]),
            .out_value (seg_d[c])
        );

        assign seg_valid[c]        = seg_v[c];
        assign seg_tag[c*TW +: TW] = seg_t[c];

        for (genvar r = 0; r < NROW; r++) begin : g_row
            logic sel;
            assign sel = cfg_we && (cfg_col == CW'(c)) && (cfg_row == RW'(r));

            bbus_slot #(.AW(AW), .DW(DW), .TW(TW), .MY_TAG(c * NROW + r)) u_slot (
                .clk       (clk),
                .rst_n     (rst_n),
                .bus_valid (seg_v[c]),
                .bus_addr  (seg_a[c]),
                .bus_kind  (seg_k[c]),
                .bus_tag   (seg_t[c]),
                .bus_value (seg_d[c]),
                .cfg_hit   (sel),
                .cfg_addr  (cfg_addr),
                .cfg_kind  (kind_e'(cfg_kind)),
                .have      (sl_have[c*NROW + r]),
                .val_tag   (sl_tag[c*NROW + r]),
                .value     (sl_val[c*NROW + r])
            );
        end

        // R6: a segment only carries producers from its own or earlier columns
        p_no_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
            seg_v[c] |-> (int'(seg_t[c]) < (c + 1) * NROW));
    end

    int rd_sel;
    assign rd_sel = int'(rd_col) * NROW + int'(rd_row);

    always_comb begin
        rd_have  = 1'b0;
        rd_tag   = '0;
        rd_value = '0;
        for (int i = 0; i < NSLOT; i++) begin
            if (rd_sel == i) begin
                rd_have  = sl_have[i];
                rd_tag   = sl_tag[i];
                rd_value = sl_val[i];
            end
        end
    end

endmodule

// File: tb/bcast_window_test.sv
`timescale 1ns/100ps
module bcast_window_test;

    localparam int NCOL = 4;
    localparam int NROW = 2;
    localparam int AW   = 6;
    localparam int DW   = 16;
    localparam int CW   = 2;
    localparam int RW   = 1;
    localparam int TW   = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NCOL-1:0]    inj_valid = '0;
    logic [NCOL*RW-1:0] inj_row = '0;
    logic [NCOL*AW-1:0] inj_addr = '0;
    logic [NCOL*2-1:0]  inj_kind = '0;
    logic [NCOL*DW-1:0] inj_value = '0;
    logic [NCOL-1:0]    inj_ready;
    logic               cfg_we = 1'b0;
    logic [CW-1:0]      cfg_col = '0;
    logic [RW-1:0]      cfg_row = '0;
    logic [AW-1:0]      cfg_addr = '0;
    logic [1:0]         cfg_kind = '0;
    logic [CW-1:0]      rd_col = '0;
    logic [RW-1:0]      rd_row = '0;
    logic               rd_have;
    logic [TW-1:0]      rd_tag;
    logic [DW-1:0]      rd_value;
    logic [NCOL-1:0]    seg_valid;
    logic [NCOL*TW-1:0] seg_tag;

    int checks = 0;
    int failures = 0;
    bit reported = 0;

    always #4 clk = ~clk;

    bcast_window #(.NCOL(NCOL), .NROW(NROW), .AW(AW), .DW(DW)) uut (
        .clk(clk), .rst_n(rst_n),
        .inj_valid(inj_valid), .inj_row(inj_row), .inj_addr(inj_addr),
        .inj_kind(inj_kind), .inj_value(inj_value), .inj_ready(inj_ready),
        .cfg_we(cfg_we), .cfg_col(cfg_col), .cfg_row(cfg_row),
        .cfg_addr(cfg_addr), .cfg_kind(cfg_kind),
        .rd_col(rd_col), .rd_row(rd_row),
        .rd_have(rd_have), .rd_tag(rd_tag), .rd_value(rd_value),
        .seg_valid(seg_valid), .seg_tag(seg_tag)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drive(input int c, input int r, input int a, input int k, input int v);
        inj_valid[c] = 1'b1;
        inj_row[c*RW +: RW]   = RW'(r);
        inj_addr[c*AW +: AW]  = AW'(a);
        inj_kind[c*2 +: 2]    = 2'(k);
        inj_value[c*DW +: DW] = DW'(v);
    endtask

    task automatic clear_inj();
        inj_valid = '0;
    endtask

    task automatic watch(input int c, input int r, input int a, input int k);
        cfg_we = 1'b1;
        cfg_col = CW'(c);
        cfg_row = RW'(r);
        cfg_addr = AW'(a);
        cfg_kind = 2'(k);
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic watch_all(input int a, input int k);
        for (int c = 0; c < NCOL; c++)
            for (int r = 0; r < NROW; r++)
                watch(c, r, a, k);
    endtask

    task automatic peek(input int c, input int r, output bit h, output int t, output int v);
        rd_col = CW'(c);
        rd_row = RW'(r);
        #1;
        h = rd_have;
        t = int'(rd_tag);
        v = int'(rd_value);
    endtask

    task automatic drain();
        repeat (NCOL + 1) tick();
    endtask

    function automatic int tag_at(input int idx);
        return int'(seg_tag[idx*TW +: TW]);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        bit h;
        int t;
        int v;

        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1: reset state
        #1;
        check(inj_ready == '1, "R1 inj_ready", inj_ready, 4'hF);
        check(seg_valid == '0, "R1 seg_valid", seg_valid, 0);
        for (int s = 0; s < NCOL*NROW; s++) begin
            peek(s / NROW, s % NROW, h, t, v);
            check(h == 0, "R1 slot empty", h, 0);
        end
        tick();

        // R3 / R5 / R6: every producer position against every slot
        for (int pc = 0; pc < NCOL; pc++) begin
            for (int pr = 0; pr < NROW; pr++) begin
                int ptag;
                ptag = pc * NROW + pr;
                watch_all(5, 0);
                drive(pc, pr, 5, 0, 16'h1000 + ptag);
                #1;
                check(seg_valid == NCOL'(1 << pc) && tag_at(pc) == ptag,
                      "R5 segment at inject", tag_at(pc), ptag);
                tick();
                clear_inj();
                for (int k = 1; k < NCOL - pc; k++) begin
                    #1;
                    check(seg_valid == NCOL'(1 << (pc + k)) && tag_at(pc + k) == ptag,
                          "R5 segment delay", seg_valid, 1 << (pc + k));
                    tick();
                end
                #1;
                check(seg_valid == '0, "R6 not past last column", seg_valid, 0);
                tick();
                for (int s = 0; s < NCOL*NROW; s++) begin
                    bit exp_h;
                    exp_h = (ptag < s);
                    peek(s / NROW, s % NROW, h, t, v);
                    check(h == exp_h, "R3 forward-only capture", h, exp_h);
                    if (exp_h)
                        check(t == ptag && v == 16'h1000 + ptag, "R3 captured value", v, 16'h1000 + ptag);
                end
            end
        end

        // R2: address and kind must both match
        watch(3, 1, 9, 1);
        drive(0, 0, 9, 0, 16'h2001); tick(); clear_inj(); drain();
        peek(3, 1, h, t, v);
        check(h == 0, "R2 kind mismatch reg", h, 0);
        drive(0, 0, 8, 1, 16'h2002); tick(); clear_inj(); drain();
        peek(3, 1, h, t, v);
        check(h == 0, "R2 address mismatch", h, 0);
        drive(0, 0, 9, 2, 16'h2003); tick(); clear_inj(); drain();
        peek(3, 1, h, t, v);
        check(h == 0, "R2 kind mismatch pred", h, 0);
        drive(0, 0, 9, 1, 16'h2004); tick(); clear_inj(); drain();
        peek(3, 1, h, t, v);
        check(h == 1 && v == 16'h2004, "R2 full match", v, 16'h2004);

        // R4: newer overrides, older ignored, equal tag accepted
        watch(3, 1, 9, 0);
        drive(2, 0, 9, 0, 16'h3004); tick(); clear_inj(); drain();
        drive(1, 1, 9, 0, 16'h3003); tick(); clear_inj(); drain();
        peek(3, 1, h, t, v);
        check(h == 1 && t == 4 && v == 16'h3004, "R4 older ignored", v, 16'h3004);
        drive(2, 1, 9, 0, 16'h3005); tick(); clear_inj(); drain();
        peek(3, 1, h, t, v);
        check(t == 5 && v == 16'h3005, "R4 newer overrides", v, 16'h3005);
        drive(2, 1, 9, 0, 16'h3055); tick(); clear_inj(); drain();
        peek(3, 1, h, t, v);
        check(t == 5 && v == 16'h3055, "R4 equal tag accepted", v, 16'h3055);
        drive(3, 0, 9, 0, 16'h3006); tick(); clear_inj(); drain();
        peek(3, 1, h, t, v);
        check(t == 6 && v == 16'h3006, "R4 same column earlier row", v, 16'h3006);

        // R7 / R8: collision in column 1
        watch_all(12, 0);
        drive(0, 0, 12, 0, 16'h4000);
        #1;
        check(seg_valid == 4'b0001 && tag_at(0) == 0, "R7 first inject", seg_valid, 1);
        tick();
        clear_inj();
        drive(1, 1, 12, 0, 16'h4003);
        #1;
        check(inj_ready[1] == 1'b1, "R7 ready before collision", inj_ready[1], 1);
        check(seg_valid[1] && tag_at(1) == 3, "R7 later tag first", tag_at(1), 3);
        tick();
        clear_inj();
        drive(1, 0, 12, 0, 16'h4BAD);
        #1;
        check(inj_ready[1] == 1'b0, "R7 ready low while parked", inj_ready[1], 0);
        check(seg_valid[1] && tag_at(1) == 0, "R7 parked result next cycle", tag_at(1), 0);
        check(seg_valid[2] && tag_at(2) == 3, "R7 winner moved on", tag_at(2), 3);
        tick();
        clear_inj();
        #1;
        check(inj_ready[1] == 1'b1 && !seg_valid[1], "R8 refused inject not driven", seg_valid[1], 0);
        check(seg_valid[2] && tag_at(2) == 0 && seg_valid[3] && tag_at(3) == 3,
              "R7 order kept downstream", tag_at(2), 0);
        tick();
        #1;
        check(seg_valid == 4'b1000 && tag_at(3) == 0, "R7 delayed arrival last column", tag_at(3), 0);
        drain();
        peek(0, 1, h, t, v);
        check(h && v == 16'h4000, "R7 column0 slot", v, 16'h4000);
        peek(1, 0, h, t, v);
        check(h && v == 16'h4000, "R7 parked result captured", v, 16'h4000);
        peek(1, 1, h, t, v);
        check(h && t == 0 && v == 16'h4000, "R8 refused inject absent", v, 16'h4000);
        for (int s = 4; s < NCOL*NROW; s++) begin
            peek(s / NROW, s % NROW, h, t, v);
            check(h && t == 3 && v == 16'h4003, "R4 late older result ignored", v, 16'h4003);
        end

        // R9: configuration wins over same-cycle capture, and clears
        watch_all(20, 2);
        drive(0, 0, 20, 2, 16'h5000);
        cfg_we = 1'b1; cfg_col = 0; cfg_row = 1; cfg_addr = 20; cfg_kind = 2;
        tick();
        cfg_we = 1'b0;
        clear_inj();
        drain();
        peek(0, 1, h, t, v);
        check(h == 0, "R9 cfg beats capture", h, 0);
        peek(1, 0, h, t, v);
        check(h == 1 && v == 16'h5000, "R9 neighbour captured", v, 16'h5000);
        watch(1, 0, 21, 2);
        peek(1, 0, h, t, v);
        check(h == 0, "R9 cfg clears held value", h, 0);
        drive(0, 0, 21, 2, 16'h5021); tick(); clear_inj(); drain();
        peek(1, 0, h, t, v);
        check(h == 1 && v == 16'h5021, "R9 new address watched", v, 16'h5021);

        report();
    end

endmodule